// File: doc/BRIEF.md
# Debug Mode Entry and Exit Controller

This block decides when a processor core goes into Debug Mode and when it comes back out. Outside Debug Mode it watches three possible reasons to halt: a level-sensitive request from an external debugger, a breakpoint instruction that the enable bits for the current privilege level allow to trap into debug, and a single-step completion. Inside Debug Mode it watches for exceptions and for a return-from-debug pulse. Every decision is registered. Each one appears one cycle later as a one-cycle strobe on the outputs.

On entry the controller raises a one-cycle entry pulse. The pulse carries a cause code, the next-PC value and the privilege level in effect when the decision was made. At the same time it raises a fetch redirect to the halt address. While the core is in Debug Mode, an exception redirects fetch to the debug exception address and the core stays in Debug Mode. A resume pulse redirects fetch to the stored resume address and clears the mode. The interrupt mask output stays high for the whole time the core is in Debug Mode, and it masks every interrupt, including the non-maskable one.

All pins are plain control and status signals. There is no valid/ready handshake and no back-pressure. The redirect and entry strobes last exactly one cycle, and the consumer must take them in that cycle.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: After reset, dbg_mode_o, irq_mask_o, redirect_o, enter_o and brk_exc_o are all 0.
- R2: When the core is outside Debug Mode and halt_req_i is high, the next cycle shows enter_o=1 with cause 3, redirect_o=1 and redirect_pc_o=HALT_ADDR, and Debug Mode is set.
- R3: A breakpoint (brk_i) with priv_i=2'b11 (M) enters Debug Mode with cause 1 when brk_m_en_i=1. With brk_m_en_i=0 and no other entry reason, brk_exc_o pulses one cycle later instead.
- R4: A breakpoint with priv_i=2'b00 (U) enters Debug Mode with cause 1 only when brk_u_en_i=1. Otherwise it is reported on brk_exc_o. A breakpoint at any other privilege encoding never enters Debug Mode.
- R5: With step_en_i=1 outside Debug Mode, a retire_i pulse causes entry with cause 4 one cycle later.
- R6: When several entry reasons occur in the same cycle, the breakpoint wins over the halt request, and the halt request wins over the step.
- R7: The entry pulse lasts one cycle. It presents next_pc_i and priv_i as they were in the cycle of the decision.
- R8: An exc_i pulse in Debug Mode gives redirect_pc_o=EXC_ADDR one cycle later, and the core stays in Debug Mode. The exception takes precedence over a resume in the same cycle.
- R9: irq_mask_o is high exactly while dbg_mode_o is high.
- R10: A resume_i pulse in Debug Mode, with no exception in the same cycle, clears Debug Mode one cycle later and redirects to the resume_pc_i value sampled in the resume cycle.
- R11: In Debug Mode, halt_req_i, brk_i, retire_i and step_en_i cause no entry pulse and no brk_exc_o. Outside Debug Mode, exc_i and resume_i cause no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| halt_req_i | input | 1 | Level-sensitive halt request from the debugger |
| brk_i | input | 1 | Breakpoint instruction executed (pulse) |
| retire_i | input | 1 | Instruction retired (pulse) |
| exc_i | input | 1 | Exception raised (pulse) |
| resume_i | input | 1 | Return from Debug Mode (pulse) |
| priv_i | input | 2 | Current privilege: 2'b11 machine, 2'b00 user |
| step_en_i | input | 1 | Single-step enable |
| brk_m_en_i | input | 1 | Breakpoints in M-mode enter Debug Mode |
| brk_u_en_i | input | 1 | Breakpoints in U-mode enter Debug Mode |
| next_pc_i | input | ADDR_W | Address of the next instruction to execute |
| resume_pc_i | input | ADDR_W | Stored resume address |
| redirect_o | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc_o | output | ADDR_W | Redirect target |
| enter_o | output | 1 | One-cycle Debug Mode entry pulse |
| enter_cause_o | output | 3 | Entry cause: 1 breakpoint, 3 halt, 4 step |
| enter_pc_o | output | ADDR_W | Captured next PC |
| enter_priv_o | output | 2 | Captured privilege level |
| brk_exc_o | output | 1 | Breakpoint reported as an ordinary exception |
| dbg_mode_o | output | 1 | Core is in Debug Mode |
| irq_mask_o | output | 1 | Mask every interrupt, including the non-maskable one |

## Verification
The bench builds the block with ADDR_W=32, leaves HALT_ADDR at its default and sets EXC_ADDR to a value unlike the default. With the addresses kept distinct, a swapped redirect target shows up directly at the outputs. The small input space makes a full sweep affordable. Outside Debug Mode, the bench drives every combination of halt, breakpoint, retire, the three enable bits and all four privilege encodings. Inside Debug Mode, it drives every combination of exception, resume, halt, breakpoint and retire. Together these two sweeps cover every priority collision and every privilege gate.

// File: rtl/dbg_ctrl_pkg.sv
package dbg_ctrl_pkg;
  localparam int CAUSE_W = 3;
  localparam int NUM_SRC = 3;

  typedef logic [1:0] priv_t;
  localparam priv_t PRIV_U = 2'b00;
  localparam priv_t PRIV_M = 2'b11;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_BRK  = 3'd1,
    CAUSE_HALT = 3'd3,
    CAUSE_STEP = 3'd4
  } dbg_cause_e;

  // Source index order is the entry priority: lowest index wins.
  function automatic dbg_cause_e src_cause(input int idx);
    case (idx)
      0:       return CAUSE_BRK;
      1:       return CAUSE_HALT;
      default: return CAUSE_STEP;
    endcase
  endfunction
endpackage

// File: rtl/dbg_entry_arb.sv
module dbg_entry_arb
  import dbg_ctrl_pkg::*;
(
  input  logic       in_dbg_i,
  input  logic       halt_i,
  input  logic       brk_i,
  input  logic       retire_i,
  input  logic       step_en_i,
  input  logic       brk_m_en_i,
  input  logic       brk_u_en_i,
  input  priv_t      priv_i,
  output logic       enter_o,
  output dbg_cause_e cause_o,
  output logic       brk_exc_o
);
  logic                brk_ok;
  logic [NUM_SRC-1:0]  req;
  logic                found;

  assign brk_ok = ((priv_i == PRIV_M) && brk_m_en_i) ||
                  ((priv_i == PRIV_U) && brk_u_en_i);

  assign req[0] = !in_dbg_i && brk_i && brk_ok;
  assign req[1] = !in_dbg_i && halt_i;
  assign req[2] = !in_dbg_i && step_en_i && retire_i;

  always_comb begin
    cause_o = CAUSE_NONE;
    found   = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && !found) begin
        cause_o = src_cause(i);
        found   = 1'b1;
      end
    end
  end

  assign enter_o   = |req;
  assign brk_exc_o = !in_dbg_i && brk_i && !enter_o;
endmodule

// File: rtl/dbg_redirect_reg.sv
module dbg_redirect_reg #(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] HALT_ADDR = 32'h1A11_0800,
  parameter logic [ADDR_W-1:0] EXC_ADDR  = 32'h1A11_0808
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_halt_i,
  input  logic              go_exc_i,
  input  logic              go_resume_i,
  input  logic [ADDR_W-1:0] resume_pc_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] pc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pc_o    <= '0;
    end else begin
      valid_o <= go_halt_i || go_exc_i || go_resume_i;
      if (go_exc_i)         pc_o <= EXC_ADDR;
      else if (go_halt_i)   pc_o <= HALT_ADDR;
      else if (go_resume_i) pc_o <= resume_pc_i;
    end
  end
endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
  import dbg_ctrl_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] HALT_ADDR = 32'h1A11_0800,
  parameter logic [ADDR_W-1:0] EXC_ADDR  = 32'h1A11_0808
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_req_i,
  input  logic              brk_i,
  input  logic              retire_i,
  input  logic              exc_i,
  input  logic              resume_i,
  input  logic [1:0]        priv_i,
  input  logic              step_en_i,
  input  logic              brk_m_en_i,
  input  logic              brk_u_en_i,
  input  logic [ADDR_W-1:0] next_pc_i,
  input  logic [ADDR_W-1:0] resume_pc_i,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] redirect_pc_o,
  output logic              enter_o,
  output logic [2:0]        enter_cause_o,
  output logic [ADDR_W-1:0] enter_pc_o,
  output logic [1:0]        enter_priv_o,
  output logic              brk_exc_o,
  output logic              dbg_mode_o,
  output logic              irq_mask_o
);
  logic       dbg_q;
  logic       enter_d;
  logic       brk_exc_d;
  dbg_cause_e cause_d;
  logic       exc_in_dbg;
  logic       resume_go;

  dbg_entry_arb u_arb (
    .in_dbg_i  (dbg_q),
    .halt_i    (halt_req_i),
    .brk_i     (brk_i),
    .retire_i  (retire_i),
    .step_en_i (step_en_i),
    .brk_m_en_i(brk_m_en_i),
    .brk_u_en_i(brk_u_en_i),
    .priv_i    (priv_i),
    .enter_o   (enter_d),
    .cause_o   (cause_d),
    .brk_exc_o (brk_exc_d)
  );

  assign exc_in_dbg = dbg_q && exc_i;
  assign resume_go  = dbg_q && resume_i && !exc_i;

  dbg_redirect_reg #(
    .ADDR_W   (ADDR_W),
    .HALT_ADDR(HALT_ADDR),
    .EXC_ADDR (EXC_ADDR)
  ) u_redir (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_halt_i  (enter_d),
    .go_exc_i   (exc_in_dbg),
    .go_resume_i(resume_go),
    .resume_pc_i(resume_pc_i),
    .valid_o    (redirect_o),
    .pc_o       (redirect_pc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbg_q         <= 1'b0;
      enter_o       <= 1'b0;
      enter_cause_o <= CAUSE_NONE;
      enter_pc_o    <= '0;
      enter_priv_o  <= PRIV_U;
      brk_exc_o     <= 1'b0;
    end else begin
      enter_o   <= enter_d;
      brk_exc_o <= brk_exc_d;
      if (enter_d) begin
        dbg_q         <= 1'b1;
        enter_cause_o <= cause_d;
        enter_pc_o    <= next_pc_i;
        enter_priv_o  <= priv_i;
      end else if (resume_go) begin
        dbg_q <= 1'b0;
      end
    end
  end

  assign dbg_mode_o = dbg_q;
  assign irq_mask_o = dbg_q;

  a_r2_halt_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbg_mode_o && halt_req_i && !brk_i) |=>
      (enter_o && enter_cause_o == 3'd3 && redirect_o && redirect_pc_o == HALT_ADDR));

  a_r5_step_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbg_mode_o && step_en_i && retire_i && !halt_req_i && !brk_i) |=>
      (enter_o && enter_cause_o == 3'd4));

  a_r7_entry_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_o |=> !enter_o);

  a_r7_entry_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbg_mode_o && halt_req_i) |=> (enter_pc_o == $past(next_pc_i) && enter_priv_o == $past(priv_i)));

  a_r8_exc_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_mode_o && exc_i) |=> (dbg_mode_o && redirect_o && redirect_pc_o == EXC_ADDR));

  a_r9_mask_on_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_o |-> irq_mask_o);

  a_r10_resume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_mode_o && resume_i && !exc_i) |=>
      (!dbg_mode_o && redirect_o && redirect_pc_o == $past(resume_pc_i)));

  a_r11_quiet_in_dbg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_mode_o |=> (!enter_o && !brk_exc_o));
endmodule

// File: tb/dbg_mode_ctrl_tb.sv
module dbg_mode_ctrl_tb;
  localparam logic [31:0] HALT_A = 32'h1A11_0800;
  localparam logic [31:0] EXC_A  = 32'h0000_0F40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt, brk, ret, exc, res, step_en, m_en, u_en;
  logic [1:0]  priv;
  logic [31:0] npc, rpc;
  logic        redir, enter, bexc, dmode, mask;
  logic [31:0] rpc_o, epc;
  logic [2:0]  cause;
  logic [1:0]  epriv;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dbg_mode_ctrl #(.ADDR_W(32), .EXC_ADDR(EXC_A)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .halt_req_i(halt), .brk_i(brk), .retire_i(ret),
    .exc_i(exc), .resume_i(res), .priv_i(priv), .step_en_i(step_en),
    .brk_m_en_i(m_en), .brk_u_en_i(u_en), .next_pc_i(npc), .resume_pc_i(rpc),
    .redirect_o(redir), .redirect_pc_o(rpc_o), .enter_o(enter),
    .enter_cause_o(cause), .enter_pc_o(epc), .enter_priv_o(epriv),
    .brk_exc_o(bexc), .dbg_mode_o(dmode), .irq_mask_o(mask)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_pulses();
    halt = 0; brk = 0; ret = 0; exc = 0; res = 0;
  endtask

  // Drive one cycle of stimulus, then sample after the registering edge.
  task automatic cycle(input logic h, input logic b, input logic r, input logic e, input logic rs);
    @(negedge clk);
    halt = h; brk = b; ret = r; exc = e; res = rs;
    @(negedge clk);
    clear_pulses();
  endtask

  task automatic do_resume(input logic [31:0] target);
    rpc = target;
    cycle(0, 0, 0, 0, 1);
    chk("R10 dbg cleared", {31'b0, dmode}, 32'd0);
    chk("R10 redirect", {31'b0, redir}, 32'd1);
    chk("R10 target", rpc_o, target);
    chk("R9 mask low", {31'b0, mask}, 32'd0);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_pulses();
    step_en = 0; m_en = 0; u_en = 0; priv = 2'b11; npc = '0; rpc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 dbg", {31'b0, dmode}, 0);
    chk("R1 mask", {31'b0, mask}, 0);
    chk("R1 redirect", {31'b0, redir}, 0);
    chk("R1 enter", {31'b0, enter}, 0);
    chk("R1 brk_exc", {31'b0, bexc}, 0);

    // Sweep outside Debug Mode: R2..R7, R9, R11 (exc/res outside debug).
    for (int v = 0; v < 256; v++) begin
      logic h, b, r, s, me, ue, take, ent, ee, rr;
      logic [1:0] p;
      logic [2:0] ec;
      h = v[0]; b = v[1]; r = v[2]; s = v[3]; me = v[4]; ue = v[5]; p = v[7:6];
      ee = v[2] ^ v[5]; rr = v[0] ^ v[3];
      step_en = s; m_en = me; u_en = ue; priv = p;
      npc = 32'h8000_0000 + 32'(v) * 4;
      take = b && ((p == 2'b11 && me) || (p == 2'b00 && ue));
      ent  = take || h || (s && r);
      ec   = take ? 3'd1 : (h ? 3'd3 : 3'd4);
      cycle(h, b, r, ee, rr && !ent);
      step_en = 0;
      chk(p == 2'b11 ? "R3 enter" : (p == 2'b00 ? "R4 enter" : "R6 enter"),
          {31'b0, enter}, {31'b0, ent});
      chk("R2 dbg set", {31'b0, dmode}, {31'b0, ent});
      chk("R9 mask", {31'b0, mask}, {31'b0, ent});
      chk("R11 redirect only on entry", {31'b0, redir}, {31'b0, ent});
      chk("R3 R4 brk_exc", {31'b0, bexc}, {31'b0, b && !ent});
      if (ent) begin
        chk("R6 cause", {29'b0, cause}, {29'b0, ec});
        chk("R5 R2 halt target", rpc_o, HALT_A);
        chk("R7 pc capture", epc, npc);
        chk("R7 priv capture", {30'b0, epriv}, {30'b0, p});
        @(negedge clk);
        chk("R7 one cycle", {31'b0, enter}, 0);
        do_resume(32'h4000_0000 + 32'(v));
      end
    end

    // Sweep inside Debug Mode: R8, R10, R11.
    for (int v = 0; v < 32; v++) begin
      logic e, rs, h, b, r;
      e = v[0]; rs = v[1]; h = v[2]; b = v[3]; r = v[4];
      step_en = 0; m_en = 1; u_en = 1; priv = 2'b11;
      cycle(1, 0, 0, 0, 0);
      chk("R2 enter for inner sweep", {31'b0, dmode}, 1);
      step_en = 1;
      rpc = 32'h2000_0000 + 32'(v) * 16;
      cycle(h, b, r, e, rs);
      chk("R11 no entry in debug", {31'b0, enter}, 0);
      chk("R11 no brk_exc in debug", {31'b0, bexc}, 0);
      chk("R8 R10 redirect", {31'b0, redir}, {31'b0, e || rs});
      if (e) chk("R8 exc target", rpc_o, EXC_A);
      else if (rs) chk("R10 resume target", rpc_o, 32'h2000_0000 + 32'(v) * 16);
      chk("R8 R10 mode", {31'b0, dmode}, {31'b0, e || !rs});
      chk("R9 mask tracks mode", {31'b0, mask}, {31'b0, dmode});
      step_en = 0;
      if (dmode) do_resume(32'h1234_5678);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule